// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits on a cartridge's CPU write path and turns writes into the lower half of the 16-bit address space (0x0000 to 0x7FFF) into banking commands. It holds a ROM bank number, a RAM bank number, a RAM enable flag and a banking mode bit. It drives them as registered outputs for the address decoder and storage arrays. Those lie outside this block.

A static parameter picks one of two controller variants. The legacy variant builds a 7-bit ROM bank from a 5-bit low field and a 2-bit shared field. A mode bit redirects that 2-bit field to the RAM bank instead. The wide variant has a 9-bit ROM bank, written as a low byte and a single top bit, and a 4-bit RAM bank. In both variants a low ROM field written as zero reads back as one. Both bank numbers are trimmed to the power-of-two cartridge sizes given as parameters.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After synchronous reset the ROM bank is 1, the RAM bank is 0, RAM enable is 0 and the mode bit is 0.
- R2: A write with address[15:13] = 000 sets RAM enable to 1 when data[3:0] equals 4'hA and to 0 for any other value, in both variants.
- R3: Legacy variant: a write with address[15:13] = 001 replaces ROM bank bits [4:0] with data[4:0], using 1 when data[4:0] is zero; bits [6:5] are kept.
- R4: Legacy variant: a write with address[15:13] = 010 loads data[1:0] into the RAM bank when the mode bit is 1, and otherwise loads data[1:0] into ROM bank bits [6:5], leaving the RAM bank unchanged.
- R5: Legacy variant: a write with address[15:13] = 011 sets the mode bit to data[0].
- R6: Wide variant: a write with address[15:12] = 0010 replaces ROM bank bits [7:0] with data, using 8'h01 when data is zero; bit 8 is kept.
- R7: Wide variant: a write with address[15:12] = 0011 sets ROM bank bit 8 to data[0], keeping bits [7:0].
- R8: Wide variant: a write with address[15:13] = 010 loads data[3:0] into the RAM bank.
- R9: Wide variant: a write with address[15:13] = 011 changes nothing, and the mode bit stays 0.
- R10: After every write the ROM bank is ANDed with (ROM_BANKS − 1) and the RAM bank with (RAM_BANKS − 1). The zero-to-one substitution is applied before this mask.
- R11: A cycle with wr_en low, or with address bit 15 set, leaves all outputs unchanged.
- R12: Outputs change at the rising clock edge that samples the write, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rom_bank | output | 9 | Selected switchable ROM bank |
| ram_bank | output | 4 | Selected RAM bank |
| ram_en | output | 1 | RAM access enable |
| bank_mode | output | 1 | Banking mode bit (legacy variant only) |

## Verification
The assertions check several properties on every cycle:
- both bank numbers stay within their cartridge sizes;
- the enable flag follows the 4'hA nibble rule;
- the state holds when no command arrives, and the wide variant ignores the top command region;
- in the legacy variant, a shared-field write in ROM mode leaves the RAM bank alone, and the low ROM field never settles at zero.

Only the bench's scenarios can show the exact bank values after a sequence. These include:
- how the mode bit steers later shared-field writes;
- the keep-and-replace split between the low and high ROM fields;
- truncation when a cartridge is smaller than the field;
- the one-edge latency.

The bench checks these against its own reference model for both variants.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int ROM_NUM_W = 9;
  localparam int RAM_NUM_W = 4;

  localparam int VAR_LEGACY = 0;
  localparam int VAR_WIDE   = 1;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RAM_EN,
    CMD_ROM_LO,
    CMD_ROM_HI,
    CMD_SEL2,
    CMD_MODE
  } cmd_e;

  typedef struct packed {
    logic [ROM_NUM_W-1:0] rom;
    logic [RAM_NUM_W-1:0] ram;
    logic                 en;
    logic                 mode;
  } bank_state_t;

endpackage

// File: rtl/cbc_cmd_decode.sv
module cbc_cmd_decode
  import cbc_pkg::*;
#(
  parameter int VARIANT = VAR_LEGACY
) (
  input  logic       wr_en,
  input  logic [3:0] addr_hi,
  output cmd_e       cmd
);

  logic       in_range;
  logic [1:0] region;
  logic       page_bit;

  assign in_range = wr_en && !addr_hi[3];
  assign region   = addr_hi[2:1];
  assign page_bit = addr_hi[0];

  generate
    if (VARIANT == VAR_LEGACY) begin : g_legacy
      logic unused_page;
      assign unused_page = page_bit;
      always_comb begin
        cmd = CMD_NONE;
        if (in_range) begin
          case (region)
            2'd0:    cmd = CMD_RAM_EN;
            2'd1:    cmd = CMD_ROM_LO;
            2'd2:    cmd = CMD_SEL2;
            default: cmd = CMD_MODE;
          endcase
        end
      end
    end else begin : g_wide
      always_comb begin
        cmd = CMD_NONE;
        if (in_range) begin
          case (region)
            2'd0:    cmd = CMD_RAM_EN;
            2'd1:    cmd = page_bit ? CMD_ROM_HI : CMD_ROM_LO;
            2'd2:    cmd = CMD_SEL2;
            default: cmd = CMD_NONE;
          endcase
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cbc_next_state.sv
module cbc_next_state
  import cbc_pkg::*;
#(
  parameter int VARIANT   = VAR_LEGACY,
  parameter int ROM_BANKS = 128,
  parameter int RAM_BANKS = 4
) (
  input  cmd_e        cmd,
  input  logic [7:0]  data,
  input  bank_state_t cur,
  output bank_state_t nxt
);

  localparam logic [ROM_NUM_W-1:0] ROM_MASK = ROM_NUM_W'(ROM_BANKS - 1);
  localparam logic [RAM_NUM_W-1:0] RAM_MASK = RAM_NUM_W'(RAM_BANKS - 1);

  bank_state_t raw;

  generate
    if (VARIANT == VAR_LEGACY) begin : g_legacy
      logic [4:0] lo5;
      logic       unused_data;
      assign unused_data = ^data[7:5];
      assign lo5 = (data[4:0] == 5'd0) ? 5'd1 : data[4:0];
      always_comb begin
        raw = cur;
        case (cmd)
          CMD_ROM_LO: raw.rom = {2'b00, cur.rom[6:5], lo5};
          CMD_SEL2: begin
            if (cur.mode) raw.ram = {2'b00, data[1:0]};
            else          raw.rom = {2'b00, data[1:0], cur.rom[4:0]};
          end
          CMD_MODE:   raw.mode = data[0];
          default:    raw = cur;
        endcase
      end
    end else begin : g_wide
      logic [7:0] lo8;
      assign lo8 = (data == 8'd0) ? 8'd1 : data;
      always_comb begin
        raw = cur;
        case (cmd)
          CMD_ROM_LO: raw.rom = {cur.rom[8], lo8};
          CMD_ROM_HI: raw.rom = {data[0], cur.rom[7:0]};
          CMD_SEL2:   raw.ram = data[3:0];
          default:    raw = cur;
        endcase
        raw.mode = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    nxt = raw;
    if (cmd == CMD_RAM_EN) nxt.en = (data[3:0] == 4'hA);
    nxt.rom = raw.rom & ROM_MASK;
    nxt.ram = raw.ram & RAM_MASK;
  end

endmodule

// File: rtl/cbc_state_reg.sv
module cbc_state_reg
  import cbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  bank_state_t nxt,
  output bank_state_t q
);

  localparam bank_state_t RESET_STATE = '{rom: ROM_NUM_W'(1), ram: '0, en: 1'b0, mode: 1'b0};

  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_STATE;
    else if (load) q <= nxt;
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int VARIANT   = VAR_LEGACY,
  parameter int ROM_BANKS = 128,
  parameter int RAM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [15:0]          wr_addr,
  input  logic [7:0]           wr_data,
  output logic [ROM_NUM_W-1:0] rom_bank,
  output logic [RAM_NUM_W-1:0] ram_bank,
  output logic                 ram_en,
  output logic                 bank_mode
);

  cmd_e        cmd;
  bank_state_t cur;
  bank_state_t nxt;
  logic        unused_addr_bits;

  assign unused_addr_bits = ^wr_addr[11:0];

  cbc_cmd_decode #(.VARIANT(VARIANT)) u_decode (
    .wr_en   (wr_en),
    .addr_hi (wr_addr[15:12]),
    .cmd     (cmd)
  );

  cbc_next_state #(
    .VARIANT   (VARIANT),
    .ROM_BANKS (ROM_BANKS),
    .RAM_BANKS (RAM_BANKS)
  ) u_next (
    .cmd  (cmd),
    .data (wr_data),
    .cur  (cur),
    .nxt  (nxt)
  );

  cbc_state_reg u_state (
    .clk  (clk),
    .rst  (rst),
    .load (cmd != CMD_NONE),
    .nxt  (nxt),
    .q    (cur)
  );

  assign rom_bank  = cur.rom;
  assign ram_bank  = cur.ram;
  assign ram_en    = cur.en;
  assign bank_mode = cur.mode;

  logic cmd_wr;
  assign cmd_wr = wr_en && !wr_addr[15];

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rom_bank == ROM_NUM_W'(1) && ram_bank == '0 && !ram_en && !bank_mode)); // R1
  AST_RAM_EN_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[15:13] == 3'b000) |=> (ram_en == $past(wr_data[3:0] == 4'hA))); // R2
  AST_ROM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(rom_bank) < ROM_BANKS); // R10
  AST_RAM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(ram_bank) < RAM_BANKS); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en) && $stable(bank_mode))); // R11

  generate
    if (VARIANT == VAR_LEGACY) begin : g_ast_legacy
      AST_SEL2_ROM_KEEPS_RAM: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wr_addr[14:13] == 2'b10 && !bank_mode) |=> $stable(ram_bank)); // R4
      if (ROM_BANKS >= 32) begin : g_lo_nz
        AST_ROM_LO_NONZERO: assert property (@(posedge clk) disable iff (rst)
          (cmd_wr && wr_addr[14:13] == 2'b01) |=> (rom_bank[4:0] != 5'd0)); // R3
      end
    end else begin : g_ast_wide
      AST_WIDE_TOP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wr_addr[14:13] == 2'b11) |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en) && $stable(bank_mode))); // R9
      if (ROM_BANKS >= 256) begin : g_lo_nz
        AST_WIDE_LO_NONZERO: assert property (@(posedge clk) disable iff (rst)
          (cmd_wr && wr_addr[14:12] == 3'b010) |=> (rom_bank[7:0] != 8'd0)); // R6
      end
    end
  endgenerate

endmodule

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int L_ROM = 64;
  localparam int L_RAM = 4;
  localparam int W_ROM = 512;
  localparam int W_RAM = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;

  logic [8:0] l_rom, w_rom;
  logic [3:0] l_ram, w_ram;
  logic       l_en, w_en, l_mode, w_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference state
  int rl_rom, rl_ram, rl_en, rl_mode;
  int rw_rom, rw_ram, rw_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctrl #(.VARIANT(0), .ROM_BANKS(L_ROM), .RAM_BANKS(L_RAM)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_bank(l_rom), .ram_bank(l_ram), .ram_en(l_en), .bank_mode(l_mode));

  cart_bank_ctrl #(.VARIANT(1), .ROM_BANKS(W_ROM), .RAM_BANKS(W_RAM)) u_dut_wide (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_bank(w_rom), .ram_bank(w_ram), .ram_en(w_en), .bank_mode(w_mode));

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "legacy rom_bank", int'(l_rom), rl_rom);
    chk(tag, "legacy ram_bank", int'(l_ram), rl_ram);
    chk(tag, "legacy ram_en", int'(l_en), rl_en);
    chk(tag, "legacy bank_mode", int'(l_mode), rl_mode);
    chk(tag, "wide rom_bank", int'(w_rom), rw_rom);
    chk(tag, "wide ram_bank", int'(w_ram), rw_ram);
    chk(tag, "wide ram_en", int'(w_en), rw_en);
    chk(tag, "wide bank_mode", int'(w_mode), 0);
  endtask

  task automatic ref_update(int a, int d);
    int lo;
    if (a[15]) return;
    case ((a >> 13) & 3)
      0: begin rl_en = ((d & 15) == 10); rw_en = ((d & 15) == 10); end
      1: begin
        lo = d & 31; if (lo == 0) lo = 1;
        rl_rom = (rl_rom & 'h60) | lo;
        if (a[12] == 1'b0) begin
          lo = d & 255; if (lo == 0) lo = 1;
          rw_rom = (rw_rom & 'h100) | lo;
        end else begin
          rw_rom = (rw_rom & 'hFF) | ((d & 1) << 8);
        end
      end
      2: begin
        if (rl_mode != 0) rl_ram = d & 3;
        else rl_rom = (rl_rom & 'h1F) | ((d & 3) << 5);
        rw_ram = d & 15;
      end
      default: rl_mode = d & 1;
    endcase
    rl_rom &= L_ROM - 1; rl_ram &= L_RAM - 1;
    rw_rom &= W_ROM - 1; rw_ram &= W_RAM - 1;
  endtask

  task automatic do_write(int a, int d, string tag);
    wr_en = 1'b1; wr_addr = a[15:0]; wr_data = d[7:0];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    ref_update(a, d);
    compare_all(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rl_rom = 1; rl_ram = 0; rl_en = 0; rl_mode = 0;
    rw_rom = 1; rw_ram = 0; rw_en = 0;
    @(negedge clk);
    compare_all("R1");
  endtask

  task automatic t_ram_enable();
    do_write('h0000, 'h0A, "R2");
    do_write('h1FFF, 'h3A, "R2");
    do_write('h0123, 'h0B, "R2");
    do_write('h1000, 'hFA, "R2");
    do_write('h0800, 'hA0, "R2");
  endtask

  task automatic t_legacy_rom();
    do_write('h2000, 'h13, "R3");
    do_write('h3FFF, 'h00, "R3");
    do_write('h2000, 'hE5, "R3");
  endtask

  task automatic t_legacy_sel2();
    do_write('h6000, 'h00, "R5");
    do_write('h4000, 'h01, "R4");
    do_write('h2000, 'h07, "R4");
    do_write('h6000, 'h01, "R5");
    do_write('h4000, 'h03, "R4");
    do_write('h5ABC, 'h02, "R4");
    do_write('h6000, 'hFE, "R5");
  endtask

  task automatic t_wide();
    do_write('h2000, 'hC3, "R6");
    do_write('h3000, 'h01, "R7");
    do_write('h2FFF, 'h00, "R6");
    do_write('h3000, 'hFE, "R7");
    do_write('h4000, 'h05, "R8");
    do_write('h5000, 'h0F, "R10");
    do_write('h6000, 'h01, "R9");
    do_write('h7FFF, 'hFF, "R9");
  endtask

  task automatic t_mask();
    do_write('h6000, 'h00, "R10");
    do_write('h4000, 'h02, "R10");
    do_write('h2000, 'h00, "R10");
    do_write('h4000, 'h03, "R10");
  endtask

  task automatic t_idle();
    wr_en = 1'b0; wr_addr = 16'h2000; wr_data = 8'h1F;
    repeat (2) @(negedge clk);
    compare_all("R11");
    do_write('hA000, 'h0A, "R11");
    do_write('hC000, 'h00, "R11");
  endtask

  task automatic t_latency();
    wr_en = 1'b1; wr_addr = 16'h2000; wr_data = 8'h09;
    #(CLK_PERIOD/4);
    compare_all("R12");
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    ref_update('h2000, 'h09);
    compare_all("R12");
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      int a, d;
      a = int'($urandom_range(0, 16'hFFFF));
      d = int'($urandom_range(0, 255));
      do_write(a, d, "R10");
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ram_enable();
    t_legacy_rom();
    t_legacy_sel2();
    t_wide();
    t_mask();
    t_idle();
    t_latency();
    t_random();
    t_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule